// File: doc/BRIEF.md
# Resistor-Ladder Key Decoder

Several push buttons share one analog sense line. A resistor divider gives every button its own voltage, and a 10-bit converter samples that line. This block takes each converted sample, decides which of nine buttons that voltage stands for, and reports a button only when the reading holds steady. A separate active-low key-down line, which is low while any button is held, gates the whole decision.

Each accepted sample is placed in one of nine decision windows, or in a no-key region above the highest window. A candidate button becomes the reported button after three consecutive valid samples agree while the key-down line is low. The block then raises a one-cycle press event and holds the button code. When the key-down line returns high, the block raises a one-cycle release event and the code returns to the no-key value.

Top module: `keyladder_decoder`

## Requirements
- R1: After reset, `key_code` reads 4'hF (no key), and `key_press` and `key_release` are both low.
- R2: With a 3.0 V full scale, each button's nominal code is round(millivolts*1024/3000). The buttons, in code order 0 to 8, are record (0 mV), app1 (598), app2 (890), app3 (1167), app4 (1452), up (1734), right (2017), left (2296) and down (2579). This gives nominal codes 0, 204, 304, 398, 496, 592, 688, 784 and 880. A sample is assigned to button k when it is at or above the midpoint below k (rounded down) and below the midpoint above k. The midpoints are 102, 254, 351, 447, 544, 640, 736 and 832.
- R3: A sample at or above 928 is treated as no key. It never leads to a press and it restarts qualification.
- R4: When three consecutive valid samples decode to the same button while `key_n` is low, `key_press` pulses for one cycle. `key_code` takes that button's code in the same cycle, one clock after the third sample is captured.
- R5: A valid sample that decodes to a different button restarts qualification. That button then counts as its own first sample.
- R6: Cycles with `adc_valid` low leave the qualification count unchanged.
- R7: A clock edge that sees `key_n` high discards any partial qualification, so a valid sample taken with `key_n` high never counts.
- R8: On the first clock edge that sees `key_n` high while a button is held, `key_release` pulses for one cycle and `key_code` returns to 4'hF in that same cycle. With no button held, `key_n` high raises no release.
- R9: While a button is held, further samples change neither `key_code` nor produce a second press until a release.
- R10: `key_press` and `key_release` are never high together. `key_code` changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_valid | input | 1 | Marks a new sample on `adc_sample` |
| adc_sample | input | 10 | Converted sense-line voltage |
| key_n | input | 1 | Key-down line, low while any button is held |
| key_code | output | 4 | Held button 0 to 8, or 4'hF for none |
| key_press | output | 1 | One-cycle pulse when a button is accepted |
| key_release | output | 1 | One-cycle pulse when a held button is let go |

## Verification
The assertions check the following on every cycle:
- press and release never coincide, and each event follows the key-line state it needs;
- the held code moves only alongside an event;
- a press always carries a real button code, and a release always leaves the no-key code;
- the window comparisons form a clean thermometer.

Only the bench scenarios can show where each window edge falls, because the assertions do not compute the divider voltages. The bench sweeps every one of the 1024 sample codes against thresholds it derives from the millivolt list. The same applies to the exact count of agreeing samples and to how invalid cycles, mismatches and key-up cycles reshape that count.

// File: rtl/kld_pkg.sv
package kld_pkg;
    localparam int ADC_W    = 10;
    localparam int N_KEYS   = 9;
    localparam int KEY_W    = 4;
    localparam int FULL_MV  = 3000;
    localparam logic [KEY_W-1:0] NO_KEY = 4'hF;

    // Divider voltage of each button in millivolts, indexed by button code.
    function automatic int key_mv(input int k);
        case (k)
            0:       return 0;
            1:       return 598;
            2:       return 890;
            3:       return 1167;
            4:       return 1452;
            5:       return 1734;
            6:       return 2017;
            7:       return 2296;
            default: return 2579;
        endcase
    endfunction

    function automatic int key_nominal(input int k);
        return (key_mv(k) * (1 << ADC_W) + FULL_MV / 2) / FULL_MV;
    endfunction

    // Lower edge of window k+1; the last entry is the upper edge of the top window.
    function automatic int key_edge(input int k);
        if (k < N_KEYS - 1)
            return (key_nominal(k) + key_nominal(k + 1)) / 2;
        return key_nominal(N_KEYS - 1)
             + (key_nominal(N_KEYS - 1) - key_nominal(N_KEYS - 2)) / 2;
    endfunction
endpackage

// File: rtl/kld_classifier.sv
module kld_classifier
    import kld_pkg::*;
(
    input  logic [ADC_W-1:0] sample,
    output logic [KEY_W-1:0] hit
);
    logic [N_KEYS-1:0] above;

    for (genvar k = 0; k < N_KEYS; k++) begin : g_edge
        localparam logic [ADC_W:0] EDGE = (ADC_W+1)'(key_edge(k));
        assign above[k] = {1'b0, sample} >= EDGE;
    end

    always_comb begin
        if (above[N_KEYS-1])
            hit = NO_KEY;
        else
            hit = KEY_W'($countones(above));
    end

    always_comb begin
        for (int k = 1; k < N_KEYS; k++) begin
            AST_WINDOW_THERMO: assert (!above[k] || above[k-1]); // R2
        end
    end
endmodule

// File: rtl/kld_qualifier.sv
module kld_qualifier
    import kld_pkg::*;
#(
    parameter int STABLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [KEY_W-1:0] hit,
    input  logic             key_n,
    output logic [KEY_W-1:0] code,
    output logic             press,
    output logic             rel
);
    localparam int CNT_W = $clog2(STABLE + 1);

    typedef struct packed {
        logic [KEY_W-1:0] cand;
        logic [CNT_W-1:0] cnt;
        logic [KEY_W-1:0] code;
        logic             press;
        logic             rel;
    } qual_t;

    localparam qual_t QUAL_RST = '{cand: NO_KEY, cnt: '0, code: NO_KEY,
                                   press: 1'b0, rel: 1'b0};

    qual_t st_d, st_q;
    logic [CNT_W-1:0] run_d;

    always_comb begin
        st_d       = st_q;
        st_d.press = 1'b0;
        st_d.rel   = 1'b0;
        run_d      = (hit == st_q.cand) ? st_q.cnt + 1'b1 : CNT_W'(1);
        if (key_n) begin
            st_d.cand = NO_KEY;
            st_d.cnt  = '0;
            if (st_q.code != NO_KEY) begin
                st_d.rel  = 1'b1;
                st_d.code = NO_KEY;
            end
        end else if (valid && st_q.code == NO_KEY) begin
            if (hit == NO_KEY) begin
                st_d.cand = NO_KEY;
                st_d.cnt  = '0;
            end else if (run_d == CNT_W'(STABLE)) begin
                st_d.code  = hit;
                st_d.press = 1'b1;
                st_d.cand  = NO_KEY;
                st_d.cnt   = '0;
            end else begin
                st_d.cand = hit;
                st_d.cnt  = run_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= QUAL_RST;
        else        st_q <= st_d;
    end

    assign code  = st_q.code;
    assign press = st_q.press;
    assign rel   = st_q.rel;

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(press && rel)); // R10
    AST_CODE_MOVES_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> (press || rel)); // R10
    AST_PRESS_REAL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> (code < KEY_W'(N_KEYS))); // R4
    AST_PRESS_NEEDS_KEYDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> $past(valid && !key_n)); // R4
    AST_RELEASE_NEEDS_KEYUP: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> ($past(key_n) && code == NO_KEY)); // R8
    AST_NO_REPRESS_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (code != NO_KEY) |=> !press); // R9
endmodule

// File: rtl/keyladder_decoder.sv
module keyladder_decoder
    import kld_pkg::*;
#(
    parameter int STABLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_sample,
    input  logic             key_n,
    output logic [KEY_W-1:0] key_code,
    output logic             key_press,
    output logic             key_release
);
    logic [KEY_W-1:0] hit;

    kld_classifier u_classifier (
        .sample (adc_sample),
        .hit    (hit)
    );

    kld_qualifier #(.STABLE(STABLE)) u_qualifier (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (adc_valid),
        .hit   (hit),
        .key_n (key_n),
        .code  (key_code),
        .press (key_press),
        .rel   (key_release)
    );
endmodule

// File: tb/keyladder_decoder_tb.sv
module keyladder_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adc_valid = 1'b0;
    logic [9:0] adc_sample = '0;
    logic       key_n = 1'b1;
    logic [3:0] key_code;
    logic       key_press;
    logic       key_release;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    keyladder_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_sample(adc_sample),
        .key_n(key_n), .key_code(key_code), .key_press(key_press),
        .key_release(key_release)
    );

    // Bench-side model of the windows, from the millivolt list.
    int mv_tab[9] = '{0, 598, 890, 1167, 1452, 1734, 2017, 2296, 2579};

    function automatic int nom(input int k);
        return (mv_tab[k] * 1024 + 1500) / 3000;
    endfunction

    function automatic int expect_key(input int v);
        int top;
        top = nom(8) + (nom(8) - nom(7)) / 2;
        if (v >= top) return 15;
        for (int k = 8; k >= 1; k--)
            if (v >= (nom(k - 1) + nom(k)) / 2) return k;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs at a falling edge; return at the next falling edge.
    task automatic tick(input bit v, input int s, input bit kn);
        adc_valid  = v;
        adc_sample = 10'(s);
        key_n      = kn;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int e;
        @(negedge clk);
        tick(0, 0, 1);
        tick(0, 0, 1);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1 code", key_code, 15);
        chk("R1 press", key_press, 0);
        chk("R1 release", key_release, 0);

        // R2, R3, R4, R8: every sample code, three agreeing samples then key-up
        for (int v = 0; v < 1024; v++) begin
            e = expect_key(v);
            tick(1, v, 0);
            tick(1, v, 0);
            chk("R4 no early press", key_press, 0);
            tick(1, v, 0);
            chk((e == 15) ? "R3 no-key press" : "R4 press", key_press, (e != 15));
            chk("R2 code", key_code, e);
            tick(0, 0, 1);
            chk("R8 release", key_release, (e != 15));
            chk("R8 code cleared", key_code, 15);
        end

        // R5: mismatch restarts, new button counts as its first sample
        tick(1, 204, 0); tick(1, 204, 0);
        tick(1, 500, 0); tick(1, 500, 0);
        chk("R5 no press after restart", key_press, 0);
        tick(1, 500, 0);
        chk("R5 press", key_press, 1);
        chk("R5 code", key_code, 4);
        tick(0, 0, 1);

        // R6: invalid cycles hold the count
        tick(1, 880, 0); tick(0, 0, 0); tick(0, 300, 0);
        tick(1, 880, 0); tick(0, 0, 0);
        chk("R6 no press yet", key_press, 0);
        tick(1, 880, 0);
        chk("R6 press", key_press, 1);
        chk("R6 code", key_code, 8);
        tick(0, 0, 1);

        // R7: key-up discards partial count, sample with key_n high ignored
        tick(1, 700, 0); tick(1, 700, 0); tick(1, 700, 1);
        chk("R7 no press on key-up sample", key_press, 0);
        chk("R8 no release without held key", key_release, 0);
        tick(1, 700, 0); tick(1, 700, 0);
        chk("R7 count restarted", key_press, 0);
        tick(1, 700, 0);
        chk("R7 press", key_press, 1);
        chk("R7 code", key_code, 6);

        // R9: held key ignores other samples
        for (int i = 0; i < 4; i++) begin
            tick(1, 10, 0);
            chk("R9 no second press", key_press, 0);
            chk("R9 code held", key_code, 6);
        end
        tick(0, 0, 1);
        chk("R8 release after hold", key_release, 1);
        tick(0, 0, 1);
        chk("R10 release one cycle", key_release, 0);

        // R3: out-of-range sample between matches restarts
        tick(1, 400, 0); tick(1, 400, 0); tick(1, 1000, 0); tick(1, 400, 0);
        chk("R3 restart by no-key sample", key_press, 0);
        tick(1, 400, 0);
        chk("R3 still counting", key_press, 0);
        tick(1, 400, 0);
        chk("R3 press after restart", key_press, 1);
        tick(0, 0, 0);
        chk("R10 press one cycle", key_press, 0);
        tick(0, 0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule